// File: doc/BRIEF.md
# Normalization and Rounding Assist Unit

This block is a 16-bit datapath helper that lets software floating point run faster. It offers three operations on one operand word. The first, priority search, counts the leading zeros of the word. That count is exactly the left rotate that puts the leading one at the top. The second is a multi-bit logical shift right. It leaves the round bit in the carry flag and a sticky OR of every bit lost below it in the V flag. The third is a multi-bit rotate left, used to apply the normalizing count.

One operation is computed per cycle by combinational logic. The result and the C, V and Z flags are captured in registers on the clock edge where `en` is high, and they hold while `en` is low. Exponent bookkeeping, number formats and the rounding decision are left to software, which reads C as the round bit and V as the sticky bit.

Top module: `norm_round_unit`

## Requirements
- R1: With `op` = 2'b00 (priority search) and a nonzero operand, `result` is the number of zero bits above the most significant one (0 to 15), and C and V are cleared.
- R2: A priority search on an operand of zero gives `result` = 0 and sets Z.
- R3: With `op` = 2'b01 (shift right), `result` is the operand shifted right logically by `count` (0 to 15), with zeros filled in at the top.
- R4: On a shift right with `count` > 0, C equals operand bit `count`-1, which is the last bit shifted out.
- R5: On a shift right, V is the OR of operand bits `count`-2 down to 0, so V is 0 whenever `count` < 2.
- R6: A shift right with `count` = 0 returns the operand unchanged and clears C and V.
- R7: With `op` = 2'b10 (rotate left), `result` is the operand rotated left by `count`, and C is operand bit 16-`count` for `count` > 0 or 0 for `count` = 0.
- R8: A rotate left always clears V.
- R9: For every operation, Z is set exactly when the 16-bit result is zero.
- R10: With `op` = 2'b11, the operand is passed to `result` unchanged and C and V are cleared.
- R11: While `en` is low, `result` and all flags keep their values.
- R12: A synchronous active-high `rst` sets `result` to 0, C and V to 0 and Z to 1.
- R13: The result and flags of an operation appear on the outputs after the first rising clock edge at which `en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Capture enable for result and flags |
| op | input | 2 | Operation: 00 priority, 01 shift right, 10 rotate left, 11 pass |
| operand | input | 16 | Source word |
| count | input | 4 | Shift or rotate amount |
| result | output | 16 | Registered result |
| flag_c | output | 1 | Carry: last bit shifted or rotated out |
| flag_v | output | 1 | Sticky OR of bits lost below carry |
| flag_z | output | 1 | Result-is-zero flag |

## Verification
Every result and flag is due exactly one rising edge after the inputs are presented with `en` high. The bench drives inputs on the falling edge and samples on the next falling edge, which is half a period after the capturing edge. Hold behaviour is checked by lowering `en`, changing the inputs, and sampling again one edge later to confirm the previous values remain. Each expected value comes from bench functions that walk the operand bit by bit. The same comparison is applied to directed corner operands and to a seeded random stream.

// File: rtl/nru_pkg.sv
package nru_pkg;

    localparam int DATA_W = 16;
    localparam int CNT_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        OP_PRIOR = 2'b00,
        OP_SHR   = 2'b01,
        OP_ROL   = 2'b10,
        OP_PASS  = 2'b11
    } nru_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              c;
        logic              v;
        logic              z;
    } nru_res_t;

    function automatic nru_res_t nru_pack(input logic [DATA_W-1:0] d,
                                          input logic c, input logic v);
        nru_res_t r;
        r.data = d;
        r.c    = c;
        r.v    = v;
        r.z    = (d == '0);
        return r;
    endfunction

    localparam nru_res_t NRU_RESET = '{data: '0, c: 1'b0, v: 1'b0, z: 1'b1};

endpackage

// File: rtl/nru_lead_zero.sv
module nru_lead_zero #(
    parameter int W  = 16,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  opnd,
    output logic [CW-1:0] lz
);
    logic found;

    always_comb begin
        lz    = '0;
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && opnd[i]) begin
                lz    = CW'(W - 1 - i);
                found = 1'b1;
            end
        end
    end

    // A nonzero word must hold a one at the position the count points to.
    always_comb begin
        if (opnd != '0)
            AST_PRIOR_MSB_HIT: assert (opnd[W-1-int'(lz)] == 1'b1); // R1
    end

endmodule

// File: rtl/nru_shift_right.sv
module nru_shift_right #(
    parameter int W  = 16,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  opnd,
    input  logic [CW-1:0] amt,
    output logic [W-1:0]  shifted,
    output logic          carry,
    output logic          sticky
);
    logic [W-1:0] below_mask;

    always_comb begin
        shifted = opnd >> amt;
        if (amt == '0) begin
            carry      = 1'b0;
            below_mask = '0;
        end else begin
            carry      = opnd[amt - CW'(1)];
            below_mask = (W'(1) << (amt - CW'(1))) - W'(1);
        end
        sticky = |(opnd & below_mask);
    end

    always_comb begin
        if (amt < CW'(2))
            AST_SHR_SHORT_NO_STICKY: assert (sticky == 1'b0); // R5
    end

endmodule

// File: rtl/nru_rotate_left.sv
module nru_rotate_left #(
    parameter int W  = 16,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  opnd,
    input  logic [CW-1:0] amt,
    output logic [W-1:0]  rotated,
    output logic          carry
);
    logic [2*W-1:0] doubled;

    always_comb begin
        doubled = {opnd, opnd} << amt;
        rotated = doubled[2*W-1:W];
        if (amt == '0)
            carry = 1'b0;
        else
            carry = opnd[W - int'(amt)];
    end

    always_comb begin
        if (amt != '0)
            AST_ROL_CARRY_WRAPS: assert (carry == rotated[0]); // R7
    end

endmodule

// File: rtl/norm_round_unit.sv
module norm_round_unit
    import nru_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [1:0]          op,
    input  logic [DATA_W-1:0]   operand,
    input  logic [CNT_W-1:0]    count,
    output logic [DATA_W-1:0]   result,
    output logic                flag_c,
    output logic                flag_v,
    output logic                flag_z
);
    nru_op_e           op_sel;
    logic [CNT_W-1:0]  lz_cnt;
    logic [DATA_W-1:0] shr_data, rol_data;
    logic              shr_c, shr_v, rol_c;
    nru_res_t          nxt, cur;

    assign op_sel = nru_op_e'(op);

    nru_lead_zero #(.W(DATA_W), .CW(CNT_W)) u_lz (
        .opnd (operand),
        .lz   (lz_cnt)
    );

    nru_shift_right #(.W(DATA_W), .CW(CNT_W)) u_shr (
        .opnd    (operand),
        .amt     (count),
        .shifted (shr_data),
        .carry   (shr_c),
        .sticky  (shr_v)
    );

    nru_rotate_left #(.W(DATA_W), .CW(CNT_W)) u_rol (
        .opnd    (operand),
        .amt     (count),
        .rotated (rol_data),
        .carry   (rol_c)
    );

    always_comb begin
        unique case (op_sel)
            OP_PRIOR: nxt = nru_pack(DATA_W'(lz_cnt), 1'b0, 1'b0);
            OP_SHR:   nxt = nru_pack(shr_data, shr_c, shr_v);
            OP_ROL:   nxt = nru_pack(rol_data, rol_c, 1'b0);
            default:  nxt = nru_pack(operand, 1'b0, 1'b0);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur <= NRU_RESET;
        else if (en)
            cur <= nxt;
    end

    assign result = cur.data;
    assign flag_c = cur.c;
    assign flag_v = cur.v;
    assign flag_z = cur.z;

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(result) && $stable(flag_c) && $stable(flag_v) && $stable(flag_z))); // R11
    AST_ROL_NO_STICKY: assert property (@(posedge clk) disable iff (rst)
        (en && op == 2'b10) |=> !flag_v); // R8
    AST_Z_TRACKS_RESULT: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (flag_z == (result == '0))); // R9
    AST_SHR_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (en && op == 2'b01 && count == '0) |=>
            (result == $past(operand) && !flag_c && !flag_v)); // R6
    AST_PRIOR_RANGE: assert property (@(posedge clk) disable iff (rst)
        (en && op == 2'b00) |=> (result < DATA_W && !flag_c && !flag_v)); // R1
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (en && op == 2'b11) |=> (result == $past(operand))); // R10

endmodule

// File: tb/norm_round_unit_bench.sv
module norm_round_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [15:0] operand = 16'h0;
    logic [3:0]  count = 4'h0;
    logic [15:0] result;
    logic        flag_c, flag_v, flag_z;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    norm_round_unit u_norm_round_unit (
        .clk(clk), .rst(rst), .en(en), .op(op), .operand(operand),
        .count(count), .result(result), .flag_c(flag_c),
        .flag_v(flag_v), .flag_z(flag_z)
    );

    // Expected {z, v, c, data} from the requirement text.
    function automatic logic [18:0] model(input logic [1:0] o,
                                          input logic [15:0] a,
                                          input int n);
        logic [15:0] d;
        logic c, v;
        int lz;
        d = a; c = 1'b0; v = 1'b0;
        case (o)
            2'b00: begin // R1, R2
                lz = 0;
                if (a != 0) while (a[15-lz] == 1'b0) lz++;
                d = 16'(lz);
            end
            2'b01: begin // R3, R4, R5
                for (int k = 0; k < n; k++) begin
                    v = v | c;
                    c = d[0];
                    d = {1'b0, d[15:1]};
                end
            end
            2'b10: begin // R7, R8
                for (int k = 0; k < n; k++) begin
                    c = d[15];
                    d = {d[14:0], d[15]};
                end
            end
            default: ; // R10
        endcase
        return {(d == 16'h0), v, c, d};
    endfunction

    task automatic check(input string req, input logic [18:0] exp);
        logic [18:0] act;
        act = {flag_z, flag_v, flag_c, result};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual z%b v%b c%b %h expected z%b v%b c%b %h",
                     req, act[18], act[17], act[16], act[15:0],
                     exp[18], exp[17], exp[16], exp[15:0]);
        end
    endtask

    // Present at a falling edge, capture at the rising edge, sample at the next falling edge (R13).
    task automatic run(input string req, input logic [1:0] o,
                       input logic [15:0] a, input int n);
        @(negedge clk);
        en = 1'b1; op = o; operand = a; count = 4'(n);
        @(negedge clk);
        en = 1'b0;
        check(req, model(o, a, n));
    endtask

    initial begin
        logic [18:0] held;
        repeat (3) @(negedge clk);
        check("R12 reset", {1'b1, 1'b0, 1'b0, 16'h0});
        rst = 1'b0;

        run("R2 prior zero", 2'b00, 16'h0000, 0);
        run("R1 prior msb", 2'b00, 16'h8000, 0);
        run("R1 prior lsb", 2'b00, 16'h0001, 0);
        run("R1 prior mid", 2'b00, 16'h00F3, 7);
        run("R6 shr zero count", 2'b01, 16'hA5C3, 0);
        run("R4 shr one", 2'b01, 16'h0003, 1);
        run("R5 shr sticky", 2'b01, 16'h0101, 9);
        run("R5 shr no sticky", 2'b01, 16'h0100, 9);
        run("R3 shr full", 2'b01, 16'hFFFF, 15);
        run("R9 shr to zero", 2'b01, 16'h0004, 3);
        run("R7 rol zero count", 2'b10, 16'h8001, 0);
        run("R7 rol fifteen", 2'b10, 16'h8001, 15);
        run("R8 rol wrap", 2'b10, 16'hC000, 1);
        run("R10 pass", 2'b11, 16'h1234, 5);

        // R11: change inputs with enable low; outputs keep last values.
        run("R13 setup", 2'b01, 16'hF00F, 4);
        held = model(2'b01, 16'hF00F, 4);
        @(negedge clk);
        op = 2'b10; operand = 16'h0000; count = 4'd3;
        @(negedge clk);
        check("R11 hold", held);

        for (int t = 0; t < 400; t++) begin
            logic [1:0]  ro;
            logic [15:0] ra;
            int          rn;
            ro = 2'($urandom);
            ra = 16'($urandom);
            if (t % 5 == 0) ra = ra >> ($urandom % 16);
            rn = int'($urandom % 16);
            run("R9 random", ro, ra, rn);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        process::self().srandom(32'h5EED_0042);
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R13 watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule